// File: doc/BRIEF.md
# DMA Interrupt Mask and Request Latch

This block gathers the fatal interrupt conditions raised on the DMA side of a bus-master controller. Each condition arrives as a one-cycle pulse on its own bit of an event vector. The pulse sets a sticky bit in a status register whether or not the source is enabled. Any set status bit drives a summary pending flag and a halt signal that stops the instruction sequencer. An enable register, loaded through a simple write port, chooses which sources may pull the active-low interrupt request line low.

The request is held once set. Changing the enable register does not release it. Only a read strobe on the status register releases it. That read returns the sticky bits and clears them in the same cycle, except for any bit whose source fires in that cycle. A source that is pending but masked never stops a later enabled source from raising the request.

Top module: `dmairq_top`

## Requirements
- R1: After reset the enable register reads 0x00, the status register reads 0x00, `dma_pend` and `seq_halt` are 0, and `irq_n` is 1.
- R2: A write with `mask_we` high loads `mask_wdata` into the enable register on the next clock. Bits 0, 2, 3, 4, 5 and 6 are writable. Bits 1 and 7 always read 0, and writes to them are ignored.
- R3: Source positions are: bit 6 data parity error as bus master, bit 5 bus fault, bit 4 aborted, bit 3 single step, bit 2 interrupt instruction received, bit 0 illegal instruction. A pulse on a valid bit of `src_evt` sets the same status bit one cycle later, whatever the enable value. The bit stays set until a status read.
- R4: `dma_pend` is 1 exactly when at least one status bit is set.
- R5: `seq_halt` goes to 1 one cycle after any valid source event, masked or not. It stays 1 until a status read leaves no bit set.
- R6: A valid source event whose enable bit is 1 drives `irq_n` to 0 one cycle later. While `irq_n` is 1, events whose enable bits are 0 leave it at 1.
- R7: Once low, `irq_n` stays low until a status read, even if the enable bits are cleared in the meantime.
- R8: While `stat_rd` is 1, `stat_rdata` shows the current status bits. On the next clock all status bits clear and `irq_n` returns to 1, unless an event arrives in that same cycle.
- R9: A source event in the same cycle as a status read is kept. Its status bit, `dma_pend` and `seq_halt` are set afterwards, and `irq_n` is low if that source is enabled.
- R10: Pulses on `src_evt` bits 1 and 7 have no effect on status, pending, halt or request.
- R11: A masked source that is already pending does not prevent a later enabled source from driving `irq_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt | input | 8 | One-cycle event pulses, one bit per source |
| mask_we | input | 1 | Enable register write strobe |
| mask_wdata | input | 8 | Enable register write data |
| mask_rdata | output | 8 | Enable register contents |
| stat_rd | input | 1 | Status read strobe, clears status |
| stat_rdata | output | 8 | Status register contents |
| dma_pend | output | 1 | Summary: any DMA status bit set |
| seq_halt | output | 1 | Stop request to the instruction sequencer |
| irq_n | output | 1 | Latched active-low interrupt request |

## Verification
The checker assumes that `src_evt` bits are single-cycle pulses sampled at the clock edge. It also assumes that a status read is a single-cycle strobe that may coincide with events or enable writes. Its properties only look one cycle ahead of a stimulus. The bench drives every input on the falling edge and holds each strobe for exactly one cycle. It sweeps all 256 enable values against every one of the eight event bits. Each event in the sweep is followed by a read, so the bench never relies on an input pattern outside these assumptions.

// File: rtl/dmairq_pkg.sv
// Package: shared widths and source bit positions for the DMA interrupt block.
// Assumes an 8-bit register view; the valid-bit mask marks implemented sources.
package dmairq_pkg;
    localparam int REG_W = 8;

    // Source positions (decoded by the status reader, so they are fixed)
    localparam int SRC_PARITY  = 6;
    localparam int SRC_BUSFLT  = 5;
    localparam int SRC_ABORT   = 4;
    localparam int SRC_STEP    = 3;
    localparam int SRC_INTINS  = 2;
    localparam int SRC_ILLEGAL = 0;

    localparam logic [REG_W-1:0] SRC_VALID =
        (REG_W'(1) << SRC_PARITY) | (REG_W'(1) << SRC_BUSFLT) |
        (REG_W'(1) << SRC_ABORT)  | (REG_W'(1) << SRC_STEP)   |
        (REG_W'(1) << SRC_INTINS) | (REG_W'(1) << SRC_ILLEGAL);
endpackage

// File: rtl/dmairq_mask_reg.sv
// Enable register: loads write data on a strobe, keeping only implemented bits.
// Assumes single-cycle write strobes; unimplemented bits are tied to zero.
module dmairq_mask_reg #(
    parameter int                 W     = 8,
    parameter logic [W-1:0]       VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (VALID[i]) begin : g_impl
                logic en_q;
                // Hold one enable bit, cleared by reset (source starts masked)
                always_ff @(posedge clk) begin
                    if (!rst_n)  en_q <= 1'b0;
                    else if (we) en_q <= wdata[i];
                end
                assign en[i] = en_q;
            end else begin : g_rsvd
                assign en[i] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/dmairq_status.sv
// Sticky status bank: sets bits on events, clears on read, keeps same-cycle events.
// Assumes events are pulses; also derives the pending summary from the bits.
module dmairq_status #(
    parameter int           W     = 8,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         rd,
    output logic [W-1:0] sticky,
    output logic         pend
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (VALID[i]) begin : g_impl
                logic st_q;
                // Set on event, clear on read, event wins over the clear
                always_ff @(posedge clk) begin
                    if (!rst_n)  st_q <= 1'b0;
                    else if (rd) st_q <= evt[i];
                    else         st_q <= st_q | evt[i];
                end
                assign sticky[i] = st_q;
            end else begin : g_rsvd
                assign sticky[i] = 1'b0;
            end
        end
    endgenerate

    // Summary flag: any sticky bit set
    always_comb pend = |sticky;
endmodule

// File: rtl/dmairq_req_latch.sv
// Request latch: sets on any enabled event, holds until a status read.
// Assumes the enable vector is the registered mask; set has priority over clear.
module dmairq_req_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] en,
    input  logic         clr,
    output logic         req_n
);
    logic hit;
    logic req_q;

    // Detect an event from any enabled source this cycle
    always_comb hit = |(evt & en);

    // Latch the request; only a read releases it
    always_ff @(posedge clk) begin
        if (!rst_n)   req_q <= 1'b0;
        else if (hit) req_q <= 1'b1;
        else if (clr) req_q <= 1'b0;
    end

    assign req_n = ~req_q;
endmodule

// File: rtl/dmairq_top.sv
// Top: DMA interrupt mask, sticky status, halt and latched active-low request.
// Assumes single-cycle event, write and read strobes on a common clock.
module dmairq_top #(
    parameter int                 W     = dmairq_pkg::REG_W,
    parameter logic [W-1:0]       VALID = dmairq_pkg::SRC_VALID
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_evt,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wdata,
    output logic [W-1:0] mask_rdata,
    input  logic         stat_rd,
    output logic [W-1:0] stat_rdata,
    output logic         dma_pend,
    output logic         seq_halt,
    output logic         irq_n
);
    logic [W-1:0] en;
    logic [W-1:0] evt_v;
    logic [W-1:0] sticky;
    logic         pend;

    // Drop pulses on unimplemented positions
    always_comb evt_v = src_evt & VALID;

    dmairq_mask_reg #(.W(W), .VALID(VALID)) u_mask (
        .clk(clk), .rst_n(rst_n), .we(mask_we), .wdata(mask_wdata), .en(en)
    );

    dmairq_status #(.W(W), .VALID(VALID)) u_stat (
        .clk(clk), .rst_n(rst_n), .evt(evt_v), .rd(stat_rd),
        .sticky(sticky), .pend(pend)
    );

    dmairq_req_latch #(.W(W)) u_req (
        .clk(clk), .rst_n(rst_n), .evt(evt_v), .en(en), .clr(stat_rd),
        .req_n(irq_n)
    );

    // Every source is fatal: halt follows any pending bit
    always_comb begin
        mask_rdata = en;
        stat_rdata = sticky;
        dma_pend   = pend;
        seq_halt   = pend;
    end
endmodule

// File: rtl/dmairq_checker.sv
// Checker: temporal properties of the DMA interrupt block, bound to the top.
// Assumes single-cycle strobes; every property looks at most one cycle ahead.
module dmairq_checker #(
    parameter int           W     = 8,
    parameter logic [W-1:0] VALID = '1
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] src_evt,
    input logic         mask_we,
    input logic [W-1:0] mask_wdata,
    input logic [W-1:0] mask_rdata,
    input logic         stat_rd,
    input logic [W-1:0] stat_rdata,
    input logic         dma_pend,
    input logic         seq_halt,
    input logic         irq_n
);
    assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> mask_rdata == ($past(mask_wdata) & VALID));

    assert_status_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_evt & VALID) != '0 |=> (stat_rdata & $past(src_evt & VALID)) == $past(src_evt & VALID));

    assert_pend_any_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_pend == (stat_rdata != '0));

    assert_halt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_halt && !stat_rd |=> seq_halt);

    assert_irq_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (src_evt & mask_rdata & VALID) != '0 |=> !irq_n);

    assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n && ((src_evt & mask_rdata) == '0) |=> irq_n);

    assert_irq_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n && !stat_rd |=> !irq_n);

    assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && ((src_evt & VALID) == '0) |=> !dma_pend && irq_n);

    assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rdata & ~VALID) == '0 && (mask_rdata & ~VALID) == '0);
endmodule

bind dmairq_top dmairq_checker #(.W(W), .VALID(VALID)) u_dmairq_checker (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .mask_rdata(mask_rdata), .stat_rd(stat_rd),
    .stat_rdata(stat_rdata), .dma_pend(dma_pend), .seq_halt(seq_halt),
    .irq_n(irq_n)
);

// File: tb/dmairq_top_bench.sv
// Bench: sweeps every enable value against every event bit plus directed cases.
module dmairq_top_bench;
    localparam int  CLK_PERIOD = 10;
    localparam int  W          = 8;
    localparam logic [W-1:0] VAL = 8'b0111_1101;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] src_evt = '0;
    logic         mask_we = 1'b0;
    logic [W-1:0] mask_wdata = '0;
    logic [W-1:0] mask_rdata;
    logic         stat_rd = 1'b0;
    logic [W-1:0] stat_rdata;
    logic         dma_pend;
    logic         seq_halt;
    logic         irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmairq_top u_dmairq_top (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .mask_rdata(mask_rdata), .stat_rd(stat_rd),
        .stat_rdata(stat_rdata), .dma_pend(dma_pend), .seq_halt(seq_halt),
        .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One cycle: apply inputs at a falling edge, release them at the next
    task automatic cyc(input logic [W-1:0] e, input logic rd, input logic we, input logic [W-1:0] wd);
        @(negedge clk);
        src_evt = e; stat_rd = rd; mask_we = we; mask_wdata = wd;
        @(negedge clk);
        src_evt = '0; stat_rd = 1'b0; mask_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [W-1:0] exp);
        @(negedge clk);
        stat_rd = 1'b1;
        #1 chk(req, stat_rdata, exp);
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mask", mask_rdata, 0);
        chk("R1 status", stat_rdata, 0);
        chk("R1 pend", dma_pend, 0);
        chk("R1 halt", seq_halt, 0);
        chk("R1 irq_n", irq_n, 1);

        // Sweep: every enable value against every event bit
        for (int m = 0; m < 256; m++) begin
            cyc('0, 1'b0, 1'b1, W'(m));
            chk("R2 mask readback", mask_rdata, W'(m) & VAL);
            for (int b = 0; b < W; b++) begin
                logic [W-1:0] e;
                logic         v;
                logic         hit;
                e   = W'(1) << b;
                v   = VAL[b];
                hit = v & m[b];
                cyc(e, 1'b0, 1'b0, '0);
                chk(v ? "R3 status set" : "R10 reserved evt", stat_rdata, v ? e : '0);
                chk("R4 pend", dma_pend, v);
                chk("R5 halt", seq_halt, v);
                chk("R6 irq_n", irq_n, !hit);
                rd_chk("R8 read data", v ? e : '0);
                chk("R8 cleared", stat_rdata, 0);
                chk("R8 irq release", irq_n, 1);
                chk("R5 halt release", seq_halt, 0);
            end
        end

        // Latch survives clearing the enable bits
        cyc('0, 1'b0, 1'b1, 8'hFF);
        cyc(8'h20, 1'b0, 1'b0, '0);
        cyc('0, 1'b0, 1'b1, 8'h00);
        repeat (3) @(negedge clk);
        chk("R7 irq held", irq_n, 0);
        rd_chk("R7 read", 8'h20);
        chk("R7 release", irq_n, 1);

        // Event in the same cycle as a read is kept
        cyc('0, 1'b0, 1'b1, 8'h08);
        cyc(8'h40, 1'b0, 1'b0, '0);
        chk("R9 masked no irq", irq_n, 1);
        @(negedge clk);
        src_evt = 8'h08; stat_rd = 1'b1;
        #1 chk("R9 read data", stat_rdata, 8'h40);
        @(negedge clk);
        src_evt = '0; stat_rd = 1'b0;
        chk("R9 kept bit", stat_rdata, 8'h08);
        chk("R9 pend", dma_pend, 1);
        chk("R9 halt", seq_halt, 1);
        chk("R9 irq", irq_n, 0);
        rd_chk("R9 drain", 8'h08);

        // Masked pending source does not block an enabled one
        cyc('0, 1'b0, 1'b1, 8'h01);
        cyc(8'h10, 1'b0, 1'b0, '0);
        chk("R11 masked pend", dma_pend, 1);
        chk("R11 masked irq", irq_n, 1);
        cyc(8'h01, 1'b0, 1'b0, '0);
        chk("R11 stacked status", stat_rdata, 8'h11);
        chk("R11 irq", irq_n, 0);
        rd_chk("R11 drain", 8'h11);

        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule